// File: doc/BRIEF.md
# Nearest Pixel-Rate Clock Selector

This block turns a requested pixel rate, given in kHz, into clock settings the display hardware can actually produce. The hardware offers three base oscillators (24000, 25175 and 36000 kHz), each followed by one of four rational scalers (1/3, 1/2, 2/3 and 2/2). That gives twelve candidate rates. The block walks through all twelve, one per clock, and keeps the one with the smallest absolute error. It then reports the oscillator select, the scaler code and the rate that the chosen pair delivers. For a high-resolution monochrome mode, software requests one quarter of the true pixel rate, so 24000 is requested in place of 96000.

A request is a one-cycle `reqValid` pulse. When `noRate` is high with that pulse, no rate was specified. The block then skips the search and selects the 24000 kHz oscillator together with the scaler code on `fallbackDiv`. Each accepted request is answered by a one-cycle `ack`. The three result outputs are updated on the same clock edge that raises `ack`, and they hold their values until the next answer. The block does not switch any clocks itself.

Top module: `pixrate_selector`

## Requirements
- R1: While reset is held, and after it is released, `ack` is 0 and `oscSel`, `divCode` and `rateKhz` are all 0 until the first answer.
- R2: Oscillator codes are 00 = 24000 kHz, 01 = 25175 kHz and 10 = 36000 kHz. Code 11 never appears.
- R3: Scaler codes are 00 = 1/3, 01 = 1/2, 10 = 2/3 and 11 = 2/2. A candidate rate is the oscillator rate times the scaler, rounded to the nearest kHz, with exact halves rounded down. This gives 8392, 12587 and 16783 kHz for the 25175 kHz oscillator. A request equal to a candidate returns that candidate.
- R4: A request that matches no candidate returns the candidate with the smallest absolute error. The error is computed in 24-bit unsigned arithmetic.
- R5: When one rate can be reached by two settings (24000 and 12000 kHz), the 24000 kHz oscillator (code 00) is chosen.
- R6: When two different candidate rates are equally far from the request, the lower rate is chosen.
- R7: A request with `noRate` high returns oscillator 00, `divCode` equal to `fallbackDiv`, and the 24000 kHz candidate for that scaler. `ack` is high in the cycle that follows the accepting edge.
- R8: For a request with a rate, `ack` is high only in the cycle that follows the 13th rising edge, counting the accepting edge as the first. `ack` lasts one cycle.
- R9: `reqValid` pulses arriving while a search is running are ignored. A request is accepted again from the `ack` cycle onward.
- R10: `oscSel`, `divCode` and `rateKhz` change only on the edge that raises `ack`, and otherwise hold their values.
- R11: Requests above every candidate, including 96000 and the all-ones 24-bit value, return 36000 kHz (oscillator 10, scaler 11).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | One-cycle request strobe |
| noRate | input | 1 | Request carries no rate; use the fallback setting |
| reqRate | input | 24 | Requested pixel rate in kHz |
| fallbackDiv | input | 2 | Scaler code used when `noRate` is high |
| ack | output | 1 | One-cycle answer strobe |
| oscSel | output | 2 | Chosen base oscillator code |
| divCode | output | 2 | Chosen scaler code |
| rateKhz | output | 24 | Rate delivered by the chosen pair, in kHz |

## Verification
The answer to a fallback request is due one edge after acceptance. The answer to a rate request is due twelve edges after the accepting edge. Between answers, the result outputs must not move. The bench keeps a behavioural model that counts down from the accepting edge, with a countdown integer and a fixed table of the twelve candidates. On every falling clock edge it compares `ack` and all three results against the model, so an answer that comes early, late or twice fails in the exact cycle where it goes wrong. Requests landing mid-search and back-to-back requests in the `ack` cycle test the acceptance window.

// File: rtl/pixrate_pkg.sv
package pixrate_pkg;

  localparam int NUM_OSC  = 3;
  localparam int NUM_DIV  = 4;
  localparam int NUM_CAND = NUM_OSC * NUM_DIV;
  localparam int IDX_W    = $clog2(NUM_CAND);
  localparam int LAST_IDX = NUM_CAND - 1;

  // strobes from control to datapath
  typedef struct packed {
    logic             start;
    logic             step;
    logic             commit;
    logic             loadDefault;
    logic [IDX_W-1:0] idx;
  } ctrlStrb_t;

  // oscillator rate times scaler, nearest kHz, halves rounded down
  function automatic int unsigned scaledRate(input int unsigned oscKhz, input logic [1:0] code);
    int unsigned num;
    int unsigned den;
    num = code[1] ? 2 : 1;
    den = code[0] ? 2 : 3;
    return (2 * oscKhz * num + den - 1) / (2 * den);
  endfunction

endpackage

// File: rtl/pixrate_ctrl.sv
module pixrate_ctrl
  import pixrate_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      noRate,
  output ctrlStrb_t strb,
  output logic      ack
);

  typedef enum logic { ST_IDLE, ST_SCAN } state_t;

  state_t           stateQ;
  logic [IDX_W-1:0] idxQ;
  logic             ackQ;
  logic             lastStep;

  assign lastStep = (stateQ == ST_SCAN) && (idxQ == IDX_W'(LAST_IDX));

  always_comb begin
    strb.start       = (stateQ == ST_IDLE) && reqValid && !noRate;
    strb.loadDefault = (stateQ == ST_IDLE) && reqValid && noRate;
    strb.step        = (stateQ == ST_SCAN);
    strb.commit      = lastStep;
    strb.idx         = idxQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      idxQ   <= '0;
      ackQ   <= 1'b0;
    end else begin
      ackQ <= strb.loadDefault || lastStep;
      case (stateQ)
        ST_IDLE: begin
          if (strb.start) begin
            stateQ <= ST_SCAN;
            idxQ   <= '0;
          end
        end
        default: begin
          if (lastStep) stateQ <= ST_IDLE;
          else          idxQ   <= idxQ + 1'b1;
        end
      endcase
    end
  end

  assign ack = ackQ;

  // mid-search requests do not disturb the walk
  assert_scan_ignores_req_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_SCAN && idxQ != IDX_W'(LAST_IDX))
      |=> (stateQ == ST_SCAN && idxQ == $past(idxQ) + 1'b1));

  // no answer before the walk ends
  assert_no_early_ack_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_SCAN && idxQ != IDX_W'(LAST_IDX)) |=> !ackQ);

endmodule

// File: rtl/pixrate_dpath.sv
module pixrate_dpath
  import pixrate_pkg::*;
#(
  parameter int RATE_W   = 24,
  parameter int OSC0_KHZ = 24000,
  parameter int OSC1_KHZ = 25175,
  parameter int OSC2_KHZ = 36000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [RATE_W-1:0] reqRate,
  input  logic [1:0]        fallbackDiv,
  output logic [1:0]        oscSel,
  output logic [1:0]        divCode,
  output logic [RATE_W-1:0] rateKhz
);

  localparam int TAB_N = 2 ** IDX_W;

  logic [RATE_W-1:0] candTab [TAB_N];

  for (genvar g = 0; g < TAB_N; g++) begin : g_cand
    if (g < NUM_CAND) begin : g_real
      localparam int unsigned OSC_KHZ = (g / NUM_DIV == 0) ? OSC0_KHZ :
                                        (g / NUM_DIV == 1) ? OSC1_KHZ : OSC2_KHZ;
      assign candTab[g] = RATE_W'(scaledRate(OSC_KHZ, 2'(g % NUM_DIV)));
    end else begin : g_pad
      assign candTab[g] = '0;
    end
  end

  logic [RATE_W-1:0] reqQ;
  logic [IDX_W-1:0]  bestIdx;
  logic [RATE_W-1:0] bestRate;
  logic [RATE_W-1:0] bestErr;
  logic [IDX_W-1:0]  resIdx;
  logic [RATE_W-1:0] resRate;

  logic [RATE_W-1:0] candRate;
  logic [RATE_W-1:0] candErr;
  logic              candWins;
  logic [IDX_W-1:0]  winIdx;
  logic [RATE_W-1:0] winRate;
  logic [RATE_W-1:0] winErr;
  logic [IDX_W-1:0]  defIdx;

  assign candRate = candTab[strb.idx];
  assign candErr  = (reqQ >= candRate) ? (reqQ - candRate) : (candRate - reqQ);
  // strict compare keeps the earlier (lower oscillator) on a same-rate tie
  assign candWins = (candErr < bestErr) || ((candErr == bestErr) && (candRate < bestRate));
  assign winIdx   = candWins ? strb.idx : bestIdx;
  assign winRate  = candWins ? candRate : bestRate;
  assign winErr   = candWins ? candErr  : bestErr;
  assign defIdx   = IDX_W'(fallbackDiv);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqQ     <= '0;
      bestIdx  <= '0;
      bestRate <= '1;
      bestErr  <= '1;
      resIdx   <= '0;
      resRate  <= '0;
    end else begin
      if (strb.start) begin
        reqQ     <= reqRate;
        bestIdx  <= '0;
        bestRate <= '1;
        bestErr  <= '1;
      end else if (strb.step) begin
        bestIdx  <= winIdx;
        bestRate <= winRate;
        bestErr  <= winErr;
      end
      if (strb.commit) begin
        resIdx  <= winIdx;
        resRate <= winRate;
      end else if (strb.loadDefault) begin
        resIdx  <= defIdx;
        resRate <= candTab[defIdx];
      end
    end
  end

  assign oscSel  = resIdx[IDX_W-1:2];
  assign divCode = resIdx[1:0];
  assign rateKhz = resRate;

  assert_default_pick_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadDefault |=> (oscSel == 2'b00 && divCode == $past(fallbackDiv)));

  assert_osc_code_legal_R2: assert property (@(posedge clk) disable iff (!rstN)
    oscSel != 2'b11);

endmodule

// File: rtl/pixrate_selector.sv
module pixrate_selector
  import pixrate_pkg::*;
#(
  parameter int RATE_W   = 24,
  parameter int OSC0_KHZ = 24000,
  parameter int OSC1_KHZ = 25175,
  parameter int OSC2_KHZ = 36000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              noRate,
  input  logic [RATE_W-1:0] reqRate,
  input  logic [1:0]        fallbackDiv,
  output logic              ack,
  output logic [1:0]        oscSel,
  output logic [1:0]        divCode,
  output logic [RATE_W-1:0] rateKhz
);

  ctrlStrb_t strb;

  pixrate_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .noRate   (noRate),
    .strb     (strb),
    .ack      (ack)
  );

  pixrate_dpath #(
    .RATE_W   (RATE_W),
    .OSC0_KHZ (OSC0_KHZ),
    .OSC1_KHZ (OSC1_KHZ),
    .OSC2_KHZ (OSC2_KHZ)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .reqRate     (reqRate),
    .fallbackDiv (fallbackDiv),
    .oscSel      (oscSel),
    .divCode     (divCode),
    .rateKhz     (rateKhz)
  );

  // results move only together with the answer strobe
  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(rateKhz) || !$stable(oscSel) || !$stable(divCode)) |-> ack);

endmodule

// File: tb/tb_pixrate_selector.sv
module tb_pixrate_selector;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        noRate = 1'b0;
  logic [23:0] reqRate = '0;
  logic [1:0]  fallbackDiv = '0;
  logic        ack;
  logic [1:0]  oscSel;
  logic [1:0]  divCode;
  logic [23:0] rateKhz;

  always #4 clk = ~clk;

  pixrate_selector dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .noRate(noRate),
    .reqRate(reqRate), .fallbackDiv(fallbackDiv), .ack(ack),
    .oscSel(oscSel), .divCode(divCode), .rateKhz(rateKhz)
  );

  int checks = 0;
  int errors = 0;
  string curTag = "R1";

  // candidate table, index = oscCode*4 + scalerCode
  int tab [12] = '{8000, 12000, 16000, 24000,
                   8392, 12587, 16783, 25175,
                   12000, 18000, 24000, 36000};

  // reference model state
  int mBusy = 0;
  int mAck = 0;
  int mIdx = 0, mRate = 0;
  int pIdx = 0, pRate = 0;

  function automatic int pickBest(input int req);
    int best = 0;
    for (int i = 0; i < 12; i++) begin
      int e  = (req > tab[i]) ? req - tab[i] : tab[i] - req;
      int eb = (req > tab[best]) ? req - tab[best] : tab[best] - req;
      if (e < eb || (e == eb && tab[i] < tab[best])) best = i;
    end
    return best;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mBusy <= 0; mAck <= 0; mIdx <= 0; mRate <= 0;
    end else begin
      mAck <= 0;
      if (mBusy > 0) begin
        mBusy <= mBusy - 1;
        if (mBusy == 1) begin
          mAck <= 1; mIdx <= pIdx; mRate <= pRate;
        end
      end else if (reqValid) begin
        if (noRate) begin
          mAck <= 1; mIdx <= int'(fallbackDiv); mRate <= tab[int'(fallbackDiv)];
        end else begin
          mBusy <= 12;
          pIdx  <= pickBest(int'(reqRate));
          pRate <= tab[pickBest(int'(reqRate))];
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      chk("R8", int'(ack), mAck, "ack");
      chk(curTag, int'(oscSel), mIdx / 4, "oscSel");
      chk(curTag, int'(divCode), mIdx % 4, "divCode");
      chk(curTag, int'(rateKhz), mRate, "rateKhz");
    end
  end

  task automatic issue(input int rate, input logic nr, input logic [1:0] fb);
    @(negedge clk);
    reqValid = 1'b1; noRate = nr; reqRate = 24'(rate); fallbackDiv = fb;
    @(negedge clk);
    reqValid = 1'b0; noRate = 1'b0;
  endtask

  task automatic runReq(input string tag, input int rate, input logic nr, input logic [1:0] fb);
    curTag = tag;
    issue(rate, nr, fb);
    repeat (16) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state, sampled while reset is held
    repeat (3) @(negedge clk);
    chk("R1", int'(ack), 0, "ack in reset");
    chk("R1", int'(rateKhz), 0, "rate in reset");
    chk("R1", int'(oscSel), 0, "osc in reset");
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    runReq("R5", 24000, 1'b0, 2'd0);     // 24000 via osc 00 scaler 11
    runReq("R5", 12000, 1'b0, 2'd0);     // 12000 via osc 00 scaler 01
    runReq("R3", 8392, 1'b0, 2'd0);
    runReq("R3", 16783, 1'b0, 2'd0);
    runReq("R3", 12587, 1'b0, 2'd0);
    runReq("R2", 36000, 1'b0, 2'd0);
    runReq("R4", 100, 1'b0, 2'd0);
    runReq("R4", 30000, 1'b0, 2'd0);
    runReq("R4", 17000, 1'b0, 2'd0);
    runReq("R6", 8196, 1'b0, 2'd0);      // tie 8000/8392
    runReq("R6", 10196, 1'b0, 2'd0);     // tie 8392/12000
    runReq("R6", 21000, 1'b0, 2'd0);     // tie 18000/24000
    runReq("R11", 96000, 1'b0, 2'd0);
    runReq("R11", 24'hFFFFFF, 1'b0, 2'd0);
    for (int d = 0; d < 4; d++) runReq("R7", 0, 1'b1, 2'(d));

    // R9: request during a search is dropped
    curTag = "R9";
    issue(8000, 1'b0, 2'd0);
    repeat (4) @(negedge clk);
    issue(36000, 1'b0, 2'd0);
    repeat (20) @(negedge clk);

    // R9: request in the ack cycle is accepted
    curTag = "R9";
    issue(25175, 1'b0, 2'd0);
    repeat (11) @(negedge clk);
    issue(0, 1'b1, 2'd2);
    repeat (6) @(negedge clk);

    // R10: idle outputs hold while inputs wiggle without a strobe
    curTag = "R10";
    reqRate = 24'd12000; fallbackDiv = 2'd3; noRate = 1'b1;
    repeat (6) @(negedge clk);
    noRate = 1'b0;
    repeat (2) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule